// File: doc/BRIEF.md
# Fatal and Error-State Event Logger

This block watches the trap, software-initiated reset (SIR) and watchdog-timeout strobes of a processor core, compares the current trap level with the maximum trap level, and samples uncorrectable-error flags from several sources. These sources are the system-bus address path, the level-2 cache tag, the mode-setting status register, the trap-address path, and a catch-all fatal source. Each recognised condition sets its own sticky bit in a status word that software reads through a simple register port. The same condition also raises a one-cycle request to enter the error state.

A watchdog timeout below the maximum trap level is handled in two stages. The first one only produces an asynchronous-data-error indication and arms a tracking flag. A further timeout while that flag is armed is logged as a second-timeout condition. A normal trap return below the maximum level disarms the flag. An error-state cause that has no dedicated bit sets nothing in the log and asks for a watchdog reset instead. Software clears the whole log by writing 1 to bit 0. If a detection arrives in the same cycle as that write, the detection is kept.

Top module: `fatal_event_logger`

## Requirements
- R1: A trap strobe while trapLevel equals maxTrapLevel sets log bit 8, and errStateReq pulses high in the following cycle. A trap below the maximum changes nothing.
- R2: An SIR strobe while trapLevel equals maxTrapLevel sets log bit 9 and pulses errStateReq in the following cycle.
- R3: A watchdog strobe while trapLevel equals maxTrapLevel sets log bit 10 and pulses errStateReq in the following cycle.
- R4: A watchdog strobe below the maximum trap level with no earlier unresolved timeout pulses asyncDataErr in the following cycle and sets no log bit. A later watchdog strobe below the maximum sets bit 11 and pulses errStateReq.
- R5: The mode-register uncorrectable flag sets bit 12, and the trap-address uncorrectable flag sets bit 13. Each pulses errStateReq in the following cycle.
- R6: The bus-address, L2-tag and other-fatal flags set bits 0, 1 and 2 respectively. Each pulses errStateReq in the following cycle.
- R7: Every log bit stays set until it is cleared. Bits 7:3 and all bits above 13 always read 0.
- R8: A register write with data bit 0 equal to 1 clears all log bits in the following cycle. A write with bit 0 equal to 0 leaves the log unchanged.
- R9: The unclassified error-state flag pulses wdResetReq in the following cycle and sets no log bit.
- R10: When a detection and a clearing write occur in the same cycle, the detected bit reads 1 afterwards and all other bits read 0.
- R11: A trap-return strobe while trapLevel is below maxTrapLevel disarms the first-timeout tracking, so the next timeout below the maximum acts as a first timeout again. Reset clears the log, the tracking flag and all request outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trapStrobe | input | 1 | A trap is being taken |
| sirStrobe | input | 1 | Software-initiated reset event |
| wdtStrobe | input | 1 | Watchdog timeout event |
| trapRetStrobe | input | 1 | Normal trap completion |
| trapLevel | input | TL_W | Current trap level |
| maxTrapLevel | input | TL_W | Highest trap level |
| ueBusAddr | input | 1 | Uncorrectable error on system-bus address |
| ueL2Tag | input | 1 | Uncorrectable error in L2 cache tag |
| ueOtherFatal | input | 1 | Any other fatal error |
| ueModeReg | input | 1 | Uncorrectable error in mode-setting register |
| ueTrapAddr | input | 1 | Uncorrectable error in trap base, type or address path |
| otherErrState | input | 1 | Error-state cause without a dedicated bit |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | DATA_W | Register write data |
| regRdData | output | DATA_W | Current log contents |
| errStateReq | output | 1 | Error-state entry request pulse |
| wdResetReq | output | 1 | Watchdog-reset request pulse |
| asyncDataErr | output | 1 | First watchdog-timeout indication pulse |

## Verification
Directed cases drive each strobe once at the maximum trap level and once below it. These cases show that only the at-maximum events log, and that a first timeout below the maximum signals without logging while a second one logs. Register writes are tried with bit 0 low and with bit 0 high, alone and together with a detection, to separate a no-op write, a full clear and the case where detection takes priority. A trap return is placed between two timeouts to show that tracking is disarmed. Random cycles then mix all strobes, trap levels, flags and writes against a bench model of the log and the request pulses.

// File: rtl/felog_pkg.sv
package felog_pkg;
  localparam int LOG_W        = 14;
  localparam int BIT_BUS_ADDR = 0;
  localparam int BIT_L2_TAG   = 1;
  localparam int BIT_OTHER    = 2;
  localparam int BIT_TRAP_MAX = 8;
  localparam int BIT_SIR_MAX  = 9;
  localparam int BIT_WDT_MAX  = 10;
  localparam int BIT_WDT_2ND  = 11;
  localparam int BIT_MODE_REG = 12;
  localparam int BIT_TRAP_ADR = 13;

  typedef struct packed {
    logic setBusAddr;
    logic setL2Tag;
    logic setOther;
    logic setTrapMax;
    logic setSirMax;
    logic setWdtMax;
    logic setWdt2nd;
    logic setModeReg;
    logic setTrapAdr;
    logic clearAll;
  } logStrobes_t;

  function automatic logic bitImplemented(input int idx);
    return (idx <= BIT_OTHER) || (idx >= BIT_TRAP_MAX && idx <= BIT_TRAP_ADR);
  endfunction
endpackage

// File: rtl/felog_ctrl.sv
module felog_ctrl
  import felog_pkg::*;
#(
  parameter int TL_W = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            trapStrobe,
  input  logic            sirStrobe,
  input  logic            wdtStrobe,
  input  logic            trapRetStrobe,
  input  logic [TL_W-1:0] trapLevel,
  input  logic [TL_W-1:0] maxTrapLevel,
  input  logic            ueBusAddr,
  input  logic            ueL2Tag,
  input  logic            ueOtherFatal,
  input  logic            ueModeReg,
  input  logic            ueTrapAddr,
  input  logic            otherErrState,
  input  logic            clearReq,
  output logStrobes_t     strobes,
  output logic            errStateReq,
  output logic            wdResetReq,
  output logic            asyncDataErr
);
  logic atMax;
  logic belowMax;
  logic firstSeenQ;
  logic firstNow;
  logic anySet;

  assign atMax    = (trapLevel == maxTrapLevel);
  assign belowMax = (trapLevel < maxTrapLevel);

  always_comb begin
    strobes            = '0;
    strobes.setBusAddr = ueBusAddr;
    strobes.setL2Tag   = ueL2Tag;
    strobes.setOther   = ueOtherFatal;
    strobes.setTrapMax = trapStrobe && atMax;
    strobes.setSirMax  = sirStrobe && atMax;
    strobes.setWdtMax  = wdtStrobe && atMax;
    strobes.setWdt2nd  = wdtStrobe && !atMax && firstSeenQ;
    strobes.setModeReg = ueModeReg;
    strobes.setTrapAdr = ueTrapAddr;
    strobes.clearAll   = clearReq;
  end

  assign firstNow = wdtStrobe && !atMax && !firstSeenQ;
  assign anySet   = strobes.setBusAddr | strobes.setL2Tag | strobes.setOther |
                    strobes.setTrapMax | strobes.setSirMax | strobes.setWdtMax |
                    strobes.setWdt2nd  | strobes.setModeReg | strobes.setTrapAdr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstSeenQ <= 1'b0;
    end else if (wdtStrobe && !atMax) begin
      firstSeenQ <= 1'b1;
    end else if (trapRetStrobe && belowMax) begin
      firstSeenQ <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errStateReq  <= 1'b0;
      wdResetReq   <= 1'b0;
      asyncDataErr <= 1'b0;
    end else begin
      errStateReq  <= anySet;
      wdResetReq   <= otherErrState;
      asyncDataErr <= firstNow;
    end
  end
endmodule

// File: rtl/felog_datapath.sv
module felog_datapath
  import felog_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logStrobes_t       strobes,
  output logic [DATA_W-1:0] rdData
);
  logic [LOG_W-1:0] logQ;
  logic [LOG_W-1:0] setMask;

  always_comb begin
    setMask               = '0;
    setMask[BIT_BUS_ADDR] = strobes.setBusAddr;
    setMask[BIT_L2_TAG]   = strobes.setL2Tag;
    setMask[BIT_OTHER]    = strobes.setOther;
    setMask[BIT_TRAP_MAX] = strobes.setTrapMax;
    setMask[BIT_SIR_MAX]  = strobes.setSirMax;
    setMask[BIT_WDT_MAX]  = strobes.setWdtMax;
    setMask[BIT_WDT_2ND]  = strobes.setWdt2nd;
    setMask[BIT_MODE_REG] = strobes.setModeReg;
    setMask[BIT_TRAP_ADR] = strobes.setTrapAdr;
  end

  // Detection is ORed after the clear so that a same-cycle event survives.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) logQ <= '0;
    else       logQ <= (strobes.clearAll ? '0 : logQ) | setMask;
  end

  for (genvar i = 0; i < DATA_W; i++) begin : g_rd
    if (i < LOG_W && bitImplemented(i)) begin : g_live
      assign rdData[i] = logQ[i];
    end else begin : g_zero
      assign rdData[i] = 1'b0;
    end
  end
endmodule

// File: rtl/fatal_event_logger.sv
module fatal_event_logger
  import felog_pkg::*;
#(
  parameter int TL_W   = 3,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapStrobe,
  input  logic              sirStrobe,
  input  logic              wdtStrobe,
  input  logic              trapRetStrobe,
  input  logic [TL_W-1:0]   trapLevel,
  input  logic [TL_W-1:0]   maxTrapLevel,
  input  logic              ueBusAddr,
  input  logic              ueL2Tag,
  input  logic              ueOtherFatal,
  input  logic              ueModeReg,
  input  logic              ueTrapAddr,
  input  logic              otherErrState,
  input  logic              regWrEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              errStateReq,
  output logic              wdResetReq,
  output logic              asyncDataErr
);
  logStrobes_t strobes;
  logic        clearReq;

  assign clearReq = regWrEn && regWrData[0];

  felog_ctrl #(.TL_W(TL_W)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .trapStrobe(trapStrobe), .sirStrobe(sirStrobe), .wdtStrobe(wdtStrobe),
    .trapRetStrobe(trapRetStrobe), .trapLevel(trapLevel), .maxTrapLevel(maxTrapLevel),
    .ueBusAddr(ueBusAddr), .ueL2Tag(ueL2Tag), .ueOtherFatal(ueOtherFatal),
    .ueModeReg(ueModeReg), .ueTrapAddr(ueTrapAddr), .otherErrState(otherErrState),
    .clearReq(clearReq), .strobes(strobes),
    .errStateReq(errStateReq), .wdResetReq(wdResetReq), .asyncDataErr(asyncDataErr)
  );

  felog_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdData(regRdData)
  );
endmodule

// File: rtl/fatal_event_logger_chk.sv
module fatal_event_logger_chk #(
  parameter int TL_W   = 3,
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              trapStrobe,
  input logic              sirStrobe,
  input logic              wdtStrobe,
  input logic              trapRetStrobe,
  input logic [TL_W-1:0]   trapLevel,
  input logic [TL_W-1:0]   maxTrapLevel,
  input logic              ueBusAddr,
  input logic              ueL2Tag,
  input logic              ueOtherFatal,
  input logic              ueModeReg,
  input logic              ueTrapAddr,
  input logic              otherErrState,
  input logic              regWrEn,
  input logic [DATA_W-1:0] regWrData,
  input logic [DATA_W-1:0] regRdData,
  input logic              errStateReq,
  input logic              wdResetReq,
  input logic              asyncDataErr
);
  a_r1_trap_at_max: assert property (@(posedge clk) disable iff (!rstN)
    (trapStrobe && trapLevel == maxTrapLevel) |=> (regRdData[8] && errStateReq));

  a_r2_sir_at_max: assert property (@(posedge clk) disable iff (!rstN)
    (sirStrobe && trapLevel == maxTrapLevel) |=> (regRdData[9] && errStateReq));

  a_r3_wdt_at_max: assert property (@(posedge clk) disable iff (!rstN)
    (wdtStrobe && trapLevel == maxTrapLevel) |=> (regRdData[10] && errStateReq));

  a_r4_wdt_below_max: assert property (@(posedge clk) disable iff (!rstN)
    (wdtStrobe && trapLevel != maxTrapLevel) |=> (asyncDataErr || (regRdData[11] && errStateReq)));

  a_r7_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regWrData[0]) |=> ((regRdData & $past(regRdData)) == $past(regRdData)));

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[7:3] == 5'd0) && ((regRdData >> 14) == '0));

  a_r9_wd_reset: assert property (@(posedge clk) disable iff (!rstN)
    otherErrState |=> wdResetReq);

  a_r10_detect_wins: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[0] && ueModeReg) |=> regRdData[12]);
endmodule

bind fatal_event_logger fatal_event_logger_chk #(.TL_W(TL_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_fatal_event_logger.sv
module tb_fatal_event_logger;
  localparam int TL_W   = 3;
  localparam int DATA_W = 64;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic trapStrobe = 0, sirStrobe = 0, wdtStrobe = 0, trapRetStrobe = 0;
  logic [TL_W-1:0] trapLevel = '0, maxTrapLevel = 3'd5;
  logic ueBusAddr = 0, ueL2Tag = 0, ueOtherFatal = 0, ueModeReg = 0, ueTrapAddr = 0;
  logic otherErrState = 0, regWrEn = 0;
  logic [DATA_W-1:0] regWrData = '0;
  logic [DATA_W-1:0] regRdData;
  logic errStateReq, wdResetReq, asyncDataErr;

  int checks = 0, fails = 0;
  logic [DATA_W-1:0] expLog = '0;
  logic expFirst = 1'b0;
  logic expErr = 0, expWdr = 0, expAde = 0;

  always #4 clk = ~clk;

  fatal_event_logger #(.TL_W(TL_W), .DATA_W(DATA_W)) dut (.*);

  function automatic logic [DATA_W-1:0] setBits();
    logic [DATA_W-1:0] m = '0;
    logic atMax = (trapLevel == maxTrapLevel);
    m[0]  = ueBusAddr;
    m[1]  = ueL2Tag;
    m[2]  = ueOtherFatal;
    m[8]  = trapStrobe && atMax;
    m[9]  = sirStrobe && atMax;
    m[10] = wdtStrobe && atMax;
    m[11] = wdtStrobe && !atMax && expFirst;
    m[12] = ueModeReg;
    m[13] = ueTrapAddr;
    return m;
  endfunction

  task automatic modelStep();
    logic [DATA_W-1:0] m = setBits();
    logic atMax = (trapLevel == maxTrapLevel);
    expErr = (m != '0);
    expWdr = otherErrState;
    expAde = wdtStrobe && !atMax && !expFirst;
    expLog = ((regWrEn && regWrData[0]) ? '0 : expLog) | m;
    if (wdtStrobe && !atMax) expFirst = 1'b1;
    else if (trapRetStrobe && trapLevel < maxTrapLevel) expFirst = 1'b0;
  endtask

  task automatic clearInputs();
    trapStrobe = 0; sirStrobe = 0; wdtStrobe = 0; trapRetStrobe = 0;
    ueBusAddr = 0; ueL2Tag = 0; ueOtherFatal = 0; ueModeReg = 0; ueTrapAddr = 0;
    otherErrState = 0; regWrEn = 0; regWrData = '0;
  endtask

  task automatic check(string tag);
    checks++;
    if (regRdData !== expLog || errStateReq !== expErr ||
        wdResetReq !== expWdr || asyncDataErr !== expAde) begin
      fails++;
      $display("FAIL %s: log=%h esr=%b wdr=%b ade=%b expected log=%h esr=%b wdr=%b ade=%b",
               tag, regRdData, errStateReq, wdResetReq, asyncDataErr,
               expLog, expErr, expWdr, expAde);
    end
  endtask

  // Inputs are set at a falling edge; one rising edge later the outputs are checked.
  task automatic step(string tag);
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check(tag);
    clearInputs();
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finishRun();
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R11 reset state");

    trapLevel = 3'd5; trapStrobe = 1;               step("R1 trap at max");
    trapLevel = 3'd2; trapStrobe = 1;               step("R1 trap below max ignored");
    trapLevel = 3'd5; sirStrobe = 1;                step("R2 sir at max");
    trapLevel = 3'd5; wdtStrobe = 1;                step("R3 wdt at max");
    regWrEn = 1; regWrData = 64'hFFFF_FFFF_FFFF_FFFE; step("R8 write bit0 low no effect");
    regWrEn = 1; regWrData = 64'h1;                 step("R8 clear all");
    trapLevel = 3'd1; wdtStrobe = 1;                step("R4 first timeout");
    trapLevel = 3'd1; wdtStrobe = 1;                step("R4 second timeout");
    trapLevel = 3'd1; trapRetStrobe = 1;            step("R11 trap return disarms");
    trapLevel = 3'd1; wdtStrobe = 1;                step("R11 first timeout again");
    ueModeReg = 1;                                  step("R5 mode reg UE");
    ueTrapAddr = 1;                                 step("R5 trap addr UE");
    ueBusAddr = 1;                                  step("R6 bus addr UE");
    ueL2Tag = 1;                                    step("R6 L2 tag UE");
    ueOtherFatal = 1;                               step("R6 other fatal");
    step("R7 bits stay set");
    otherErrState = 1;                              step("R9 unclassified cause");
    regWrEn = 1; regWrData = 64'h1; ueL2Tag = 1;    step("R10 detect wins over clear");

    for (int n = 0; n < 3000; n++) begin
      maxTrapLevel  = ($urandom_range(0, 7) == 0) ? 3'($urandom_range(1, 7)) : maxTrapLevel;
      trapLevel     = ($urandom_range(0, 2) == 0) ? maxTrapLevel : 3'($urandom_range(0, 7));
      trapStrobe    = ($urandom_range(0, 5) == 0);
      sirStrobe     = ($urandom_range(0, 9) == 0);
      wdtStrobe     = ($urandom_range(0, 5) == 0);
      trapRetStrobe = ($urandom_range(0, 4) == 0);
      ueBusAddr     = ($urandom_range(0, 19) == 0);
      ueL2Tag       = ($urandom_range(0, 19) == 0);
      ueOtherFatal  = ($urandom_range(0, 19) == 0);
      ueModeReg     = ($urandom_range(0, 19) == 0);
      ueTrapAddr    = ($urandom_range(0, 19) == 0);
      otherErrState = ($urandom_range(0, 9) == 0);
      regWrEn       = ($urandom_range(0, 7) == 0);
      regWrData     = {$urandom, $urandom};
      step("R7 R8 random mix");
    end
    finishRun();
  end
endmodule